// File: doc/BRIEF.md
# Selectable Metering Element Accumulator

This block takes one set of signed samples per conversion: two voltages (`vA`, `vB`) and two currents (`iA`, `iB`). A 3-bit equation code picks how the samples pair up. From them the block forms two power products and two current terms. The power products are summed over an interval. The current terms are squared and summed over the same interval.

The interval length is a number of valid samples. Idle cycles do not count toward it. On the sample that completes the interval, the block does three things at once:
- it copies the four sums, plus the total of the two power sums, to its outputs;
- it clears its accumulators;
- it raises a one-cycle done strobe.

The next interval begins with the next valid sample. Software or downstream logic reads the five results whenever the done strobe is seen. The results hold until the next interval closes.

Top module: `meter_elem_acc`

## Requirements
- R1: With `eqSel` equal to 0, and also for any code from 3 to 7, the first power term is vA*iA, the second is vA*iB, and the current terms are iA and iB.
- R2: With `eqSel` equal to 1, the first power term is vA*(iA-iB) and the second is vA*iB, each shifted right by one bit arithmetically after the multiply (rounding toward minus infinity). The current terms are iA-iB, formed at full width with no wrap, and iB.
- R3: With `eqSel` equal to 2, the power terms are vA*iA and vB*iB, and the current terms are iA and iB.
- R4: `wTotal` always equals the signed sum of `w0Sum` and `w1Sum`. It is one bit wider than either, and it updates in the same cycle as they do.
- R5: `i0SqSum` and `i1SqSum` are sums of the squares of the current terms. They are never negative, and a full interval of full-scale samples does not wrap them.
- R6: A valid sample closes the interval when it is the N-th valid sample since the last close, where N is `intervalLen`. An `intervalLen` of 0 behaves as 1. Cycles with `sampleValid` low do not count.
- R7: `sumValid` goes high in the cycle after the closing sample's clock edge, together with the new results. It is high only in cycles that follow a closing sample.
- R8: After a close, the accumulators restart from zero. The next interval's results contain only samples taken after the closing one.
- R9: `eqSel` is applied per sample, so samples taken under different codes within one interval add into the same sums.
- R10: Between done strobes the five result outputs hold their values. After reset all results are zero and `sumValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Sample set present this cycle |
| eqSel | input | 3 | Equation code for this sample |
| intervalLen | input | CNT_W | Valid samples per interval (0 acts as 1) |
| vA | input | SAMPLE_W | Voltage A, signed |
| vB | input | SAMPLE_W | Voltage B, signed |
| iA | input | SAMPLE_W | Current A, signed |
| iB | input | SAMPLE_W | Current B, signed |
| w0Sum | output | ACC_W | First element power sum, signed |
| w1Sum | output | ACC_W | Second element power sum, signed |
| i0SqSum | output | ACC_W | First squared current sum |
| i1SqSum | output | ACC_W | Second squared current sum |
| wTotal | output | ACC_W+1 | w0Sum plus w1Sum, signed |
| sumValid | output | 1 | One-cycle strobe: new results present |

## Verification
The assertions check several properties on every cycle:
- `wTotal` agrees with the two power outputs;
- the results stay still between strobes;
- the squared sums never go negative;
- the sample counter freezes on idle cycles;
- every strobe follows a sample;
- the accumulators are zero right after a close.

Some behaviour only the bench scenarios can show, because it needs the products and the counting checked against an independent model:
- the per-code wiring of the products, and the floor behaviour of the halving on odd negative products;
- that idle gaps are skipped and that an interval length of 0 or 1 closes on every sample;
- mixed codes within one interval;
- full-scale sums that must not wrap.

// File: rtl/meter_acc_pkg.sv
package meter_acc_pkg;

  localparam int NUM_LANES = 4;
  localparam int LANE_W0 = 0;
  localparam int LANE_W1 = 1;
  localparam int LANE_I0 = 2;
  localparam int LANE_I1 = 3;

  localparam logic [2:0] EQ_SPLIT_CURRENT = 3'd0;
  localparam logic [2:0] EQ_THREE_WIRE    = 3'd1;
  localparam logic [2:0] EQ_TWO_ELEMENT   = 3'd2;

  typedef struct packed {
    logic accumulate;
    logic closeInterval;
  } accStrobes_t;

endpackage

// File: rtl/acc_elem_map.sv
module acc_elem_map
  import meter_acc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0]   vA,
  input  logic signed [SAMPLE_W-1:0]   vB,
  input  logic signed [SAMPLE_W-1:0]   iA,
  input  logic signed [SAMPLE_W-1:0]   iB,
  input  logic        [2:0]            eqSel,
  output logic signed [2*SAMPLE_W:0]   pow0,
  output logic signed [2*SAMPLE_W:0]   pow1,
  output logic signed [2*SAMPLE_W+1:0] sq0,
  output logic signed [2*SAMPLE_W+1:0] sq1
);

  localparam int CUR_W  = SAMPLE_W + 1;
  localparam int PROD_W = 2*SAMPLE_W + 1;
  localparam int SQ_W   = 2*SAMPLE_W + 2;

  // Currents widened by one bit so the difference cannot wrap.
  logic signed [CUR_W-1:0] iAx, iBx, iDiff;
  assign iAx   = CUR_W'(iA);
  assign iBx   = CUR_W'(iB);
  assign iDiff = iAx - iBx;

  // Operands widened to product width before multiplying.
  logic signed [PROD_W-1:0] vAw, vBw, iAw, iBw, iDiffW;
  assign vAw    = PROD_W'(vA);
  assign vBw    = PROD_W'(vB);
  assign iAw    = PROD_W'(iA);
  assign iBw    = PROD_W'(iB);
  assign iDiffW = PROD_W'(iDiff);

  logic signed [PROD_W-1:0] prodAA, prodAB, prodBB, prodAD;
  assign prodAA = vAw * iAw;
  assign prodAB = vAw * iBw;
  assign prodBB = vBw * iBw;
  assign prodAD = vAw * iDiffW;

  logic signed [CUR_W-1:0] cur0, cur1;

  always_comb begin
    case (eqSel)
      EQ_THREE_WIRE: begin
        pow0 = prodAD >>> 1;
        pow1 = prodAB >>> 1;
        cur0 = iDiff;
        cur1 = iBx;
      end
      EQ_TWO_ELEMENT: begin
        pow0 = prodAA;
        pow1 = prodBB;
        cur0 = iAx;
        cur1 = iBx;
      end
      default: begin
        pow0 = prodAA;
        pow1 = prodAB;
        cur0 = iAx;
        cur1 = iBx;
      end
    endcase
  end

  logic signed [SQ_W-1:0] cur0w, cur1w;
  assign cur0w = SQ_W'(cur0);
  assign cur1w = SQ_W'(cur1);
  assign sq0   = cur0w * cur0w;
  assign sq1   = cur1w * cur1w;

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import meter_acc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] intervalLen,
  output accStrobes_t      strobes
);

  logic [CNT_W-1:0] sampleCount;
  logic [CNT_W:0]   nextCount;
  logic [CNT_W:0]   effLen;
  logic             lastSample;

  assign nextCount  = {1'b0, sampleCount} + 1'b1;
  assign effLen     = (intervalLen == '0) ? (CNT_W+1)'(1) : {1'b0, intervalLen};
  assign lastSample = nextCount >= effLen;

  assign strobes.accumulate    = sampleValid;
  assign strobes.closeInterval = sampleValid && lastSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
    end else if (strobes.closeInterval) begin
      sampleCount <= '0;
    end else if (sampleValid) begin
      sampleCount <= nextCount[CNT_W-1:0];
    end
  end

  // R6: idle cycles leave the count untouched
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampleCount));

  // R8: the count restarts after every close
  p_count_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.closeInterval |=> (sampleCount == '0));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import meter_acc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 48
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  accStrobes_t               strobes,
  input  logic signed [SAMPLE_W-1:0] vA,
  input  logic signed [SAMPLE_W-1:0] vB,
  input  logic signed [SAMPLE_W-1:0] iA,
  input  logic signed [SAMPLE_W-1:0] iB,
  input  logic        [2:0]          eqSel,
  output logic signed [ACC_W-1:0]   sumOut [NUM_LANES],
  output logic signed [ACC_W:0]     totalOut,
  output logic                      sumValid
);

  localparam int PROD_W = 2*SAMPLE_W + 1;
  localparam int SQ_W   = 2*SAMPLE_W + 2;

  logic signed [PROD_W-1:0] pow0, pow1;
  logic signed [SQ_W-1:0]   sq0, sq1;

  acc_elem_map #(.SAMPLE_W(SAMPLE_W)) u_map (
    .vA(vA), .vB(vB), .iA(iA), .iB(iB), .eqSel(eqSel),
    .pow0(pow0), .pow1(pow1), .sq0(sq0), .sq1(sq1)
  );

  logic signed [ACC_W-1:0] termExt [NUM_LANES];
  logic signed [ACC_W-1:0] accReg  [NUM_LANES];
  logic signed [ACC_W-1:0] accNext [NUM_LANES];

  assign termExt[LANE_W0] = ACC_W'(pow0);
  assign termExt[LANE_W1] = ACC_W'(pow1);
  assign termExt[LANE_I0] = ACC_W'(sq0);
  assign termExt[LANE_I1] = ACC_W'(sq1);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign accNext[k] = accReg[k] + termExt[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accReg[k] <= '0;
        sumOut[k] <= '0;
      end else if (strobes.closeInterval) begin
        accReg[k] <= '0;
        sumOut[k] <= accNext[k];
      end else if (strobes.accumulate) begin
        accReg[k] <= accNext[k];
      end
    end

    // R8: a close leaves the accumulator empty
    p_acc_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
      strobes.closeInterval |=> (accReg[k] == '0));

    // R10: results hold between strobes
    p_sum_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      !sumValid |-> $stable(sumOut[k]));
  end

  for (genvar k = LANE_I0; k <= LANE_I1; k++) begin : g_sq_sign
    // R5: squared sums never turn negative
    p_sq_nonneg_r5: assert property (@(posedge clk) disable iff (!rstN)
      !accReg[k][ACC_W-1] && !sumOut[k][ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totalOut <= '0;
      sumValid <= 1'b0;
    end else begin
      sumValid <= strobes.closeInterval;
      if (strobes.closeInterval) begin
        totalOut <= (ACC_W+1)'(accNext[LANE_W0]) + (ACC_W+1)'(accNext[LANE_W1]);
      end
    end
  end

endmodule

// File: rtl/meter_elem_acc.sv
module meter_elem_acc
  import meter_acc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 48,
  parameter int CNT_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic        [2:0]          eqSel,
  input  logic        [CNT_W-1:0]    intervalLen,
  input  logic signed [SAMPLE_W-1:0] vA,
  input  logic signed [SAMPLE_W-1:0] vB,
  input  logic signed [SAMPLE_W-1:0] iA,
  input  logic signed [SAMPLE_W-1:0] iB,
  output logic signed [ACC_W-1:0]    w0Sum,
  output logic signed [ACC_W-1:0]    w1Sum,
  output logic signed [ACC_W-1:0]    i0SqSum,
  output logic signed [ACC_W-1:0]    i1SqSum,
  output logic signed [ACC_W:0]      wTotal,
  output logic                       sumValid
);

  accStrobes_t             strobes;
  logic signed [ACC_W-1:0] sumOut [NUM_LANES];

  acc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .intervalLen(intervalLen), .strobes(strobes)
  );

  acc_datapath #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .vA(vA), .vB(vB), .iA(iA), .iB(iB), .eqSel(eqSel),
    .sumOut(sumOut), .totalOut(wTotal), .sumValid(sumValid)
  );

  assign w0Sum   = sumOut[LANE_W0];
  assign w1Sum   = sumOut[LANE_W1];
  assign i0SqSum = sumOut[LANE_I0];
  assign i1SqSum = sumOut[LANE_I1];

  // R4: total tracks the two power outputs
  p_total_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    wTotal == ((ACC_W+1)'(w0Sum) + (ACC_W+1)'(w1Sum)));

  // R7: a strobe only follows a valid sample
  p_done_after_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> $past(sampleValid));

endmodule

// File: tb/meter_elem_acc_tb.sv
module meter_elem_acc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int AW = 48;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [2:0] eqSel = 3'd0;
  logic [CW-1:0] intervalLen = '0;
  logic signed [SW-1:0] vA = '0, vB = '0, iA = '0, iB = '0;
  logic signed [AW-1:0] w0Sum, w1Sum, i0SqSum, i1SqSum;
  logic signed [AW:0] wTotal;
  logic sumValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  meter_elem_acc #(.SAMPLE_W(SW), .ACC_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .eqSel(eqSel),
    .intervalLen(intervalLen), .vA(vA), .vB(vB), .iA(iA), .iB(iB),
    .w0Sum(w0Sum), .w1Sum(w1Sum), .i0SqSum(i0SqSum), .i1SqSum(i1SqSum),
    .wTotal(wTotal), .sumValid(sumValid)
  );

  typedef struct {
    longint w0, w1, i0, i1, tot;
    string  tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;
  int checkCount = 0;
  int failCount = 0;
  longint mW0 = 0, mW1 = 0, mI0 = 0, mI1 = 0;
  int mCount = 0;
  string curTag = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic sendSample(input int va, input int vb, input int ia,
                            input int ib, input int eq);
    longint p0, p1, c0, c1, lenEff;
    @(negedge clk);
    sampleValid = 1'b1;
    eqSel = eq[2:0];
    vA = va[SW-1:0]; vB = vb[SW-1:0]; iA = ia[SW-1:0]; iB = ib[SW-1:0];
    if (eq == 1) begin
      p0 = (longint'(va) * (longint'(ia) - longint'(ib))) >>> 1;
      p1 = (longint'(va) * longint'(ib)) >>> 1;
      c0 = longint'(ia) - longint'(ib);
      c1 = ib;
    end else if (eq == 2) begin
      p0 = longint'(va) * ia; p1 = longint'(vb) * ib; c0 = ia; c1 = ib;
    end else begin
      p0 = longint'(va) * ia; p1 = longint'(va) * ib; c0 = ia; c1 = ib;
    end
    mW0 += p0; mW1 += p1; mI0 += c0*c0; mI1 += c1*c1;
    mCount++;
    lenEff = (intervalLen == 0) ? 1 : longint'(intervalLen);
    if (mCount >= lenEff) begin
      expItem_t it;
      it.w0 = mW0; it.w1 = mW1; it.i0 = mI0; it.i1 = mI1;
      it.tot = mW0 + mW1; it.tag = curTag;
      expQ.push_back(it);
      mW0 = 0; mW1 = 0; mI0 = 0; mI1 = 0; mCount = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      vA = 16'sh7fff; iA = 16'sh7fff; iB = -16'sh7fff; vB = 16'sh1234;
    end
  endtask

  // Monitor: compares each strobe against the oldest expected item.
  always @(negedge clk) begin
    if (rstN && sumValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected strobe", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        lastExp = e;
        check(longint'(w0Sum) == e.w0, e.tag, "w0Sum", longint'(w0Sum), e.w0);
        check(longint'(w1Sum) == e.w1, e.tag, "w1Sum", longint'(w1Sum), e.w1);
        check(longint'(i0SqSum) == e.i0, "R5", "i0SqSum", longint'(i0SqSum), e.i0);
        check(longint'(i1SqSum) == e.i1, "R5", "i1SqSum", longint'(i1SqSum), e.i1);
        check(longint'(wTotal) == e.tot, "R4", "wTotal", longint'(wTotal), e.tot);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(sumValid == 1'b0, "R10", "sumValid in reset", sumValid, 0);
    check(w0Sum == 0 && w1Sum == 0, "R10", "power sums in reset", longint'(w0Sum), 0);
    check(i0SqSum == 0 && i1SqSum == 0, "R10", "current sums in reset", longint'(i0SqSum), 0);
    check(wTotal == 0, "R10", "wTotal in reset", longint'(wTotal), 0);
    rstN = 1'b1;
    idle(2);

    // R1: code 0
    curTag = "R1"; intervalLen = 4;
    sendSample(1000, 55, 200, -300, 0);
    sendSample(-1200, 77, 150, 40, 0);
    sendSample(3000, -9, -25, 90, 0);
    sendSample(7, 8, 9, -10, 0);
    idle(2);

    // R2: code 1 with odd negative products to check floor halving
    curTag = "R2"; intervalLen = 3;
    sendSample(3, 0, 1, 2, 1);
    sendSample(-5, 0, 7, -4, 1);
    sendSample(1001, 4, -333, 221, 1);
    idle(2);

    // R3: code 2, vB must appear in the second element
    curTag = "R3"; intervalLen = 2;
    sendSample(100, -200, 300, 400, 2);
    sendSample(-1500, 2500, -35, 12, 2);
    idle(2);

    // R1: codes 5 and 7 behave as code 0
    curTag = "R1"; intervalLen = 3;
    sendSample(400, 9999, 12, 13, 5);
    sendSample(-400, 8888, 21, -31, 7);
    sendSample(11, -11, 3, 3, 3);
    idle(2);

    // R6: idle gaps do not count toward the interval
    curTag = "R6"; intervalLen = 4;
    sendSample(10, 0, 20, 30, 0); idle(3);
    sendSample(11, 0, 21, 31, 0); idle(1);
    sendSample(12, 0, 22, 32, 0); idle(4);
    sendSample(13, 0, 23, 33, 0);
    idle(2);
    check(expQ.size() == 0, "R6", "pending intervals after gaps", expQ.size(), 0);

    // R6 with R8: interval 1 closes on back-to-back samples
    curTag = "R8"; intervalLen = 1;
    sendSample(50, 1, 60, 70, 0);
    sendSample(-50, 2, 61, 71, 2);
    sendSample(51, 3, -62, 72, 1);
    idle(2);

    // R6: interval 0 acts as 1
    curTag = "R6"; intervalLen = 0;
    sendSample(9, 8, 7, 6, 0);
    sendSample(-9, -8, -7, -6, 2);
    idle(2);

    // R9: mixed codes inside one interval
    curTag = "R9"; intervalLen = 3;
    sendSample(321, 654, -111, 222, 0);
    sendSample(321, 654, -111, 222, 1);
    sendSample(321, 654, -111, 222, 2);
    idle(2);

    // R5: full-scale samples for 40 counts, largest differential current
    curTag = "R5"; intervalLen = 40;
    for (int k = 0; k < 40; k++) sendSample(-32768, -32768, -32768, 32767, 1);
    idle(2);
    curTag = "R5";
    for (int k = 0; k < 40; k++) sendSample(-32768, -32768, -32768, -32768, 2);
    idle(2);

    // R10: results hold with idle inputs after the last strobe
    for (int k = 0; k < 5; k++) begin
      idle(1);
      check(sumValid == 1'b0, "R10", "no strobe while idle", sumValid, 0);
      check(longint'(w0Sum) == lastExp.w0 && longint'(i1SqSum) == lastExp.i1,
            "R10", "held w0Sum", longint'(w0Sum), lastExp.w0);
    end
    check(expQ.size() == 0, "R7", "missing strobes", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule